// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Controller

This block is the control core of a 10-bit digitally adjustable potentiometer. A host writes to it over a three-wire, write-only serial link made of an active-low select, a data line and a serial clock. The three lines are brought into the system clock domain through synchronisers. The block shifts in a command frame and decodes it when select is released. It keeps the volatile wiper code that sets the tap position, and it drives a small nonvolatile store model that holds the code used after power-up.

Three operations come from a two-bit command code. The first sets the wiper from a data field. The second saves the present wiper into the nonvolatile store. The third restores the wiper from that store. A save holds the store busy for a set number of system cycles, and any command that completes during that time is dropped. After reset the wiper is loaded from the store, which starts at midscale.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: After reset, nv_o is 10'h200 and busy_o is 0, and within two system cycles wiper_o is loaded from the store, so it reads 10'h200.
- R2: Bits are shifted in MSB first, one on each rising serial-clock edge while select is low. In a 24-bit frame the command code is in frame bits [23:22], the next six bits are ignored, frame bits [15:6] are the wiper data (D9 first), and frame bits [5:0] are ignored. Code 00 in a 24-bit frame sets wiper_o to the data and leaves nv_o unchanged.
- R3: No register changes while a frame is being shifted in. A frame takes effect only after select goes high.
- R4: Code 10 copies wiper_o into nv_o. It is accepted in an 8-bit frame, where the code is in frame bits [7:6], and in a 24-bit frame, where the last 16 bits are ignored.
- R5: Code 11 loads wiper_o from nv_o. It is accepted in both 8-bit and 24-bit frames.
- R6: An accepted save holds busy_o high for exactly BUSY_CYCLES system cycles. A frame that completes while busy_o is high changes neither wiper_o nor nv_o.
- R7: A frame is discarded without changing any register if its bit count is neither 8 nor 24, if it uses code 01, or if it is an 8-bit frame with code 00.
- R8: The six low bits of the command byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| din_i | input | 1 | Serial data, MSB first |
| wiper_o | output | WIPER_W | Volatile wiper code |
| nv_o | output | WIPER_W | Code held in the nonvolatile store model |
| busy_o | output | 1 | High while the store is busy after a save |

## Verification
The assertions assume that the serial clock runs at no more than a quarter of the system clock, that data is stable across each rising serial-clock edge, and that select changes only while the serial clock is low. Under these conditions every serial edge is seen once after synchronisation. The bench drives each serial half-period as four system cycles. It changes data and select only while the serial clock is low, and changes its inputs on the falling system edge. Before each random frame it waits for busy_o to fall. Only the directed busy case sends a frame during a save.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CMD_BITS   = 8;
  localparam int CNT_W      = $clog2(FRAME_BITS + 8);

  typedef enum logic [1:0] {
    OP_SET    = 2'b00,
    OP_RSVD   = 2'b01,
    OP_SAVE   = 2'b10,
    OP_RESTORE = 2'b11
  } op_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic din_i,
  output logic cs_low_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic din_o
);
  // index 0: cs (idles high), 1: sclk, 2: din
  localparam logic [2:0] IDLE = 3'b001;
  logic [2:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
      last_q <= IDLE;
    end else begin
      meta_q <= {din_i, sclk_i, cs_ni};
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  logic unused_last_din;
  assign unused_last_din = last_q[2];

  assign cs_low_o    = ~sync_q[0];
  assign cs_rise_o   = sync_q[0] & ~last_q[0];
  assign sclk_rise_o = sync_q[1] & ~last_q[1];
  assign din_o       = sync_q[2];
endmodule

// File: rtl/dpot_shifter.sv
module dpot_shifter
  import dpot_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_low_i,
  input  logic                  sclk_rise_i,
  input  logic                  din_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [CNT_W-1:0]      cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      cnt_o   <= '0;
    end else if (!cs_low_i) begin
      cnt_o <= '0;
    end else if (sclk_rise_i) begin
      frame_o <= {frame_o[FRAME_BITS-2:0], din_i};
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;  // saturate so long frames stay invalid
    end
  end
endmodule

// File: rtl/dpot_nv_store.sv
module dpot_nv_store #(
  parameter int          WIPER_W     = 10,
  parameter int unsigned BUSY_CYCLES = 1000,
  parameter int unsigned NV_INIT     = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               save_i,
  input  logic [WIPER_W-1:0] save_data_i,
  output logic [WIPER_W-1:0] nv_o,
  output logic               busy_o
);
  localparam int TMR_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(BUSY_CYCLES);

  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_o  <= WIPER_W'(NV_INIT);
      tmr_q <= '0;
    end else if (save_i && !busy_o) begin
      nv_o  <= save_data_i;
      tmr_q <= TMR_LOAD;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign busy_o = (tmr_q != '0);
endmodule

// File: rtl/dpot_spi_ctrl.sv
module dpot_spi_ctrl
  import dpot_pkg::*;
#(
  parameter int          WIPER_W     = 10,
  parameter int unsigned BUSY_CYCLES = 1000,
  parameter int unsigned NV_INIT     = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               din_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic [WIPER_W-1:0] nv_o,
  output logic               busy_o
);
  localparam int DATA_MSB = FRAME_BITS - CMD_BITS - 1;

  logic cs_low, cs_rise, sclk_rise, din_s;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  boot_q;

  dpot_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_i     (sclk_i),
    .din_i      (din_i),
    .cs_low_o   (cs_low),
    .cs_rise_o  (cs_rise),
    .sclk_rise_o(sclk_rise),
    .din_o      (din_s)
  );

  dpot_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_low_i   (cs_low),
    .sclk_rise_i(sclk_rise),
    .din_i      (din_s),
    .frame_o    (frame),
    .cnt_o      (bit_cnt)
  );

  logic short_frm, long_frm;
  op_e  op;
  logic go, do_set, do_save, do_restore;
  logic [WIPER_W-1:0] set_data;

  always_comb begin
    short_frm  = (bit_cnt == CNT_W'(CMD_BITS));
    long_frm   = (bit_cnt == CNT_W'(FRAME_BITS));
    op         = short_frm ? op_e'(frame[CMD_BITS-1 -: 2]) : op_e'(frame[FRAME_BITS-1 -: 2]);
    go         = cs_rise && !busy_o && (short_frm || long_frm);
    do_set     = go && long_frm && (op == OP_SET);
    do_save    = go && (op == OP_SAVE);
    do_restore = go && (op == OP_RESTORE);
    set_data   = frame[DATA_MSB -: WIPER_W];
  end

  logic unused_bits;
  assign unused_bits = ^{frame[FRAME_BITS-3:DATA_MSB+1], frame[DATA_MSB-WIPER_W:0]};

  dpot_nv_store #(
    .WIPER_W    (WIPER_W),
    .BUSY_CYCLES(BUSY_CYCLES),
    .NV_INIT    (NV_INIT)
  ) u_nv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_i     (do_save),
    .save_data_i(wiper_o),
    .nv_o       (nv_o),
    .busy_o     (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= 1'b1;
      wiper_o <= '0;
    end else begin
      boot_q <= 1'b0;
      if (boot_q || do_restore) wiper_o <= nv_o;
      else if (do_set)          wiper_o <= set_data;
    end
  end
endmodule

// File: rtl/dpot_spi_ctrl_chk.sv
module dpot_spi_ctrl_chk
  import dpot_pkg::*;
#(
  parameter int WIPER_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_rise,
  input logic               boot_q,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [WIPER_W-1:0] wiper_o,
  input logic [WIPER_W-1:0] nv_o,
  input logic               busy_o
);
  a_r1_boot_recall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_q |=> (wiper_o == $past(nv_o)));

  a_r3_wiper_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_o) |-> $past(cs_rise || boot_q));

  a_r4_nv_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(nv_o) |-> $past(cs_rise));

  a_r6_busy_from_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise));

  a_r6_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && busy_o) |=> ($stable(wiper_o) && $stable(nv_o)));

  a_r7_bad_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && bit_cnt != CNT_W'(8) && bit_cnt != CNT_W'(24))
      |=> ($stable(wiper_o) && $stable(nv_o)));
endmodule

bind dpot_spi_ctrl dpot_spi_ctrl_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_rise(cs_rise),
  .boot_q (boot_q),
  .bit_cnt(bit_cnt),
  .wiper_o(wiper_o),
  .nv_o   (nv_o),
  .busy_o (busy_o)
);

// File: tb/sim_dpot_spi_ctrl.sv
`timescale 1ns/1ps
module sim_dpot_spi_ctrl;
  localparam int W    = 10;
  localparam int BUSY = 600;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [W-1:0] wiper, nv;
  logic busy;
  int total = 0, bad = 0;
  logic [W-1:0] exp_w = 10'h200, exp_nv = 10'h200;

  always #5 clk = ~clk;

  dpot_spi_ctrl #(.WIPER_W(W), .BUSY_CYCLES(BUSY), .NV_INIT(512)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .wiper_o(wiper), .nv_o(nv), .busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [1:0] c, input logic [9:0] d,
                                     input logic [5:0] j1, input logic [5:0] j2);
    return {c, j1, d, j2};
  endfunction

  task automatic model(input logic [23:0] f, input int n);
    logic [1:0] c;
    c = (n == 8) ? f[7:6] : f[23:22];
    if (n == 24 && c == 2'b00) exp_w = f[15:6];
    else if ((n == 8 || n == 24) && c == 2'b10) exp_nv = exp_w;
    else if ((n == 8 || n == 24) && c == 2'b11) exp_w = exp_nv;
  endtask

  task automatic shift_bits(input logic [23:0] f, input int n);
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      din = (i < 24) ? f[i] : 1'b0;
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] f, input int n);
    shift_bits(f, n);
    end_frame();
  endtask

  task automatic idle_wait();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 wiper after reset", wiper, 10'h200);
    chk("R1 nv after reset", nv, 10'h200);
    chk("R1 busy after reset", busy, 0);

    // R2 set wiper, with junk bits in ignored positions (R8)
    send(mk(2'b00, 10'h155, 6'h3f, 6'h2a), 24); model(mk(2'b00, 10'h155, 6'h3f, 6'h2a), 24);
    chk("R2 set wiper", wiper, exp_w);
    chk("R2 nv untouched", nv, 10'h200);

    // R3 no change before select rises
    shift_bits(mk(2'b00, 10'h0f0, 6'h00, 6'h00), 24);
    chk("R3 wiper held mid frame", wiper, 10'h155);
    end_frame(); model(mk(2'b00, 10'h0f0, 6'h00, 6'h00), 24);
    chk("R3 wiper after commit", wiper, 10'h0f0);

    // R4 short save, R6 busy length
    begin
      int cnt = 0;
      shift_bits(24'h0000_80, 8); cs_n = 1'b1; model(24'h80, 8);
      for (int k = 0; k < 2000; k++) begin
        @(negedge clk);
        if (busy) cnt++;
        else if (cnt != 0) break;
      end
      chk("R6 busy cycles", cnt, BUSY);
      chk("R4 short save nv", nv, 10'h0f0);
    end

    // R5 short restore with junk low bits (R8)
    send(mk(2'b00, 10'h3ff, 6'h00, 6'h00), 24); model(mk(2'b00, 10'h3ff, 6'h00, 6'h00), 24);
    send(24'h0000_ff, 8); model(24'h0000ff, 8);
    chk("R5 R8 short restore", wiper, 10'h0f0);

    // R6 command during busy ignored
    send(mk(2'b00, 10'h2aa, 6'h00, 6'h00), 24); model(mk(2'b00, 10'h2aa, 6'h00, 6'h00), 24);
    send(mk(2'b10, 10'h000, 6'h11, 6'h00), 24); model(mk(2'b10, 10'h000, 6'h11, 6'h00), 24);
    chk("R4 long save nv", nv, 10'h2aa);
    send(mk(2'b00, 10'h001, 6'h00, 6'h00), 24);
    chk("R6 busy still high", busy, 1);
    chk("R6 write ignored while busy", wiper, 10'h2aa);
    idle_wait();
    send(mk(2'b00, 10'h001, 6'h00, 6'h00), 24); model(mk(2'b00, 10'h001, 6'h00, 6'h00), 24);
    chk("R6 write after busy", wiper, 10'h001);

    // R5 long restore
    send(mk(2'b11, 10'h3c3, 6'h15, 6'h3f), 24); model(mk(2'b11, 10'h3c3, 6'h15, 6'h3f), 24);
    chk("R5 long restore", wiper, 10'h2aa);

    // R7 discarded frames
    send(mk(2'b01, 10'h055, 6'h00, 6'h00), 24);
    chk("R7 code 01", wiper, 10'h2aa);
    send(24'h0000_00, 8);
    chk("R7 short set", wiper, 10'h2aa);
    send(mk(2'b00, 10'h111, 6'h00, 6'h00), 23);
    chk("R7 23 bits", wiper, 10'h2aa);
    send(24'h000_080, 25);
    chk("R7 25 bits nv", nv, 10'h2aa);
    chk("R7 25 bits busy", busy, 0);

    // random mix
    for (int t = 0; t < 50; t++) begin
      int n, sel;
      logic [23:0] f;
      sel = $urandom_range(0, 5);
      n = (sel < 3) ? 24 : (sel == 3) ? 8 : $urandom_range(1, 30);
      f = $urandom;
      idle_wait();
      send(f, n); model(f, n);
      chk("R2 R4 R5 R7 random wiper", wiper, exp_w);
      chk("R4 random nv", nv, exp_nv);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule